// File: doc/BRIEF.md
# Delay-Line Tap Stepping Controller

This block brings two PHY delay lines, a write line (A) and a read line (B), to requested tap settings through a narrow stepping interface. The interface has a line reset, one chip enable per line, a direction select and a step clock. A one-cycle `start` in idle captures the two targets and clamps each to the legal tap window. The block then resets both lines. After the reset, line A sits at tap 16 and line B at tap 32. The block then walks line A one tap at a time until it reaches its target, and walks line B the same way afterwards.

Each tap move is made of three phases of `PHASE_CYC` clock cycles each. The first phase raises the enable and sets the direction. The second adds the step clock. The third drops the step clock and keeps the enable and direction. The reset works the same way, with the two line resets in place of an enable. A line already at its target receives no steps. `done` rises when both lines match their targets and stays high until the next accepted `start`.

Top module: `dly_tap_stepper`

## Requirements
- R1: While `rst_n` is low and after its release, every output is low: `dl_rst_a`, `dl_rst_b`, `ce_a`, `ce_b`, `inc`, `stp_clk`, `busy` and `done`.
- R2: A `start` seen in idle first issues a line reset. Both line resets are high for three phases, and `stp_clk` is high only in the middle phase. After this reset the tracked taps are 16 for line A and 32 for line B.
- R3: Every tap move is three phases of `PHASE_CYC` cycles each. The line's enable is high in all three phases, and `stp_clk` is high only in the second phase. `stp_clk` rises only when an enable or a line reset was already high in the previous cycle.
- R4: `inc`=1 selects increment and `inc`=0 selects decrement. `inc` is 1 exactly when the target is above the current tap. It stays constant while one line is being walked.
- R5: Line A reaches its target before line B receives any step. `ce_a` and `ce_b` are never high together.
- R6: A line whose target equals its post-reset tap receives no steps. The total number of `stp_clk` pulses is 1 + |A−16| + |B−32|, where A and B are the clamped targets.
- R7: `busy` is high from the edge that accepts `start` until the sequence ends. `done` rises exactly 3·PHASE_CYC·(1+steps) cycles after the accepting edge, is low while `busy` is high, and stays high until the next accepted start.
- R8: Each target is clamped to the range [`TAP_LO`, `TAP_HI`] before it is used.
- R9: `start` has no effect while `busy` is high, including in the final cycle of a sequence. The targets and taps in use do not change.
- R10: A tap counter that follows the interface (reset loads 16/32, each step-clock rise with an enable moves that line by ±1) ends at the clamped targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (honoured only in idle) |
| tgt_a | input | TAP_W | Requested tap of line A (write) |
| tgt_b | input | TAP_W | Requested tap of line B (read) |
| dl_rst_a | output | 1 | Reset request to line A |
| dl_rst_b | output | 1 | Reset request to line B |
| ce_a | output | 1 | Step enable for line A |
| ce_b | output | 1 | Step enable for line B |
| inc | output | 1 | Step direction, 1 = up, 0 = down |
| stp_clk | output | 1 | Step clock to the delay lines |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Both lines at their targets |

## Verification
Two events can fall in the same cycle: a new `start` request and the clock edge that ends a sequence and raises `done`. The bench computes the exact length of a run from its clamped targets. It places a one-cycle `start` with different targets so that the finishing edge samples it. The request must be dropped: `done` stays high, `busy` stays low and no further reset or step pulse appears. A second case places `start` in the middle of a walk and checks that the final taps still follow the first targets.

// File: rtl/dly_tap_stepper.sv
module dly_tap_stepper #(
  parameter int TAP_W     = 6,
  parameter int RST_A     = 16,
  parameter int RST_B     = 32,
  parameter int TAP_LO    = 0,
  parameter int TAP_HI    = 63,
  parameter int PHASE_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAP_W-1:0] tgt_a,
  input  logic [TAP_W-1:0] tgt_b,
  output logic             dl_rst_a,
  output logic             dl_rst_b,
  output logic             ce_a,
  output logic             ce_b,
  output logic             inc,
  output logic             stp_clk,
  output logic             busy,
  output logic             done
);
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [TAP_W-1:0] LO = TAP_W'(TAP_LO);
  localparam logic [TAP_W-1:0] HI = TAP_W'(TAP_HI);
  localparam logic [TAP_W-1:0] RA = TAP_W'(RST_A);
  localparam logic [TAP_W-1:0] RB = TAP_W'(RST_B);
  localparam logic [CW-1:0]    PL = CW'(PHASE_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_RST, S_WALK_A, S_WALK_B} st_t;

  st_t              st;
  logic [1:0]       ph;
  logic [CW-1:0]    cnt;
  logic [TAP_W-1:0] cur_a, cur_b, goal_a, goal_b;

  function automatic logic [TAP_W-1:0] clamp(input logic [TAP_W-1:0] t);
    return (t < LO) ? LO : ((t > HI) ? HI : t);
  endfunction

  wire              phase_end = (cnt == PL);
  wire              up_a      = goal_a > cur_a;
  wire              up_b      = goal_b > cur_b;
  wire [TAP_W-1:0]  nxt_a     = up_a ? cur_a + 1'b1 : cur_a - 1'b1;
  wire [TAP_W-1:0]  nxt_b     = up_b ? cur_b + 1'b1 : cur_b - 1'b1;

  assign busy     = (st != S_IDLE);
  assign dl_rst_a = (st == S_RST);
  assign dl_rst_b = (st == S_RST);
  assign ce_a     = (st == S_WALK_A);
  assign ce_b     = (st == S_WALK_B);
  assign inc      = ce_a ? up_a : (ce_b ? up_b : 1'b0);
  assign stp_clk  = busy && (ph == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ph     <= 2'd0;
      cnt    <= '0;
      cur_a  <= RA;
      cur_b  <= RB;
      goal_a <= RA;
      goal_b <= RB;
      done   <= 1'b0;
    end else if (st == S_IDLE) begin
      if (start) begin
        goal_a <= clamp(tgt_a);
        goal_b <= clamp(tgt_b);
        done   <= 1'b0;
        st     <= S_RST;
        ph     <= 2'd0;
        cnt    <= '0;
      end
    end else if (!phase_end) begin
      cnt <= cnt + CW'(1);
    end else begin
      cnt <= '0;
      ph  <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
      if (ph == 2'd2) begin
        case (st)
          S_RST: begin
            cur_a <= RA;
            cur_b <= RB;
            if (goal_a != RA)      st <= S_WALK_A;
            else if (goal_b != RB) st <= S_WALK_B;
            else begin st <= S_IDLE; done <= 1'b1; end
          end
          S_WALK_A: begin
            cur_a <= nxt_a;
            if (nxt_a == goal_a) begin
              if (goal_b != cur_b) st <= S_WALK_B;
              else begin st <= S_IDLE; done <= 1'b1; end
            end
          end
          S_WALK_B: begin
            cur_b <= nxt_b;
            if (nxt_b == goal_b) begin st <= S_IDLE; done <= 1'b1; end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_clk_after_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stp_clk) |-> $past(ce_a || ce_b || dl_rst_a));

  assert_dir_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ce_a && $past(ce_a)) || (ce_b && $past(ce_b))) |-> $stable(inc));

  assert_a_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ce_b |-> (cur_a == goal_a));

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(goal_a) && $stable(goal_b)));

  assert_goal_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (goal_a >= LO && goal_a <= HI && goal_b >= LO && goal_b <= HI));
endmodule

// File: tb/dly_tap_stepper_test.sv
module dly_tap_stepper_test;
  localparam int CLK_NS = 10;
  localparam int P  = 2;
  localparam int LO = 4;
  localparam int HI = 60;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [5:0] tgt_a = '0, tgt_b = '0;
  logic dl_rst_a, dl_rst_b, ce_a, ce_b, inc, stp_clk, busy, done;

  int vecs = 0, errs = 0;
  int ma = 0, mb = 0, pulses = 0, order_err = 0, dir_err = 0, b_seen = 0;
  int ga = 0, gb = 0;

  always #(CLK_NS/2) clk = ~clk;

  dly_tap_stepper #(.TAP_W(6), .RST_A(16), .RST_B(32), .TAP_LO(LO), .TAP_HI(HI),
                    .PHASE_CYC(P)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_a(tgt_a), .tgt_b(tgt_b),
    .dl_rst_a(dl_rst_a), .dl_rst_b(dl_rst_b), .ce_a(ce_a), .ce_b(ce_b),
    .inc(inc), .stp_clk(stp_clk), .busy(busy), .done(done));

  // behavioural tap counter (R10) with order and direction monitors (R4, R5)
  always @(posedge stp_clk) begin
    pulses++;
    if (dl_rst_a && dl_rst_b) begin ma = 16; mb = 32; end
    else if (ce_a) begin
      if (b_seen) order_err++;
      if (inc != (ga > ma)) dir_err++;
      ma = inc ? ma + 1 : ma - 1;
    end else if (ce_b) begin
      b_seen = 1;
      if (inc != (gb > mb)) dir_err++;
      mb = inc ? mb + 1 : mb - 1;
    end
  end

  function automatic int clampv(int t);
    return (t < LO) ? LO : ((t > HI) ? HI : t);
  endfunction

  function automatic int absd(int x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inj: 0 none, -1 on the finishing cycle, >0 at that sample index
  task automatic run(int ta, int tb, int inj);
    int n, len, k;
    ga = clampv(ta); gb = clampv(tb);
    n = absd(ga - 16) + absd(gb - 32);
    len = 3 * P * (1 + n) + 1;
    pulses = 0; order_err = 0; dir_err = 0; b_seen = 0;
    tgt_a = 6'(ta); tgt_b = 6'(tb);
    start = 1'b1;
    k = 0;
    do begin
      @(posedge clk); @(negedge clk);
      k++;
      start = 1'b0;
      if (k == 1) begin
        chk("R7 busy after accept", int'(busy), 1);
        chk("R7 done cleared", int'(done), 0);
        chk("R2 reset asserted", int'(dl_rst_a && dl_rst_b), 1);
      end
      if ((inj > 0 && k == inj) || (inj < 0 && k == len - 1)) begin
        start = 1'b1; tgt_a = 6'(63 - ta); tgt_b = 6'(63 - tb);
      end
    end while (!done && k < 20000);
    start = 1'b0;
    chk("R7 cycles to done", k, len);
    chk("R10 line A tap", ma, ga);
    chk("R10 line B tap", mb, gb);
    chk("R6 step pulses", pulses, 1 + n);
    chk("R5 order", order_err, 0);
    chk("R4 direction", dir_err, 0);
    if (inj != 0) begin
      repeat (20) @(negedge clk);
      chk("R9 no restart busy", int'(busy), 0);
      chk("R9 done held", int'(done), 1);
      chk("R9 no extra pulses", pulses, 1 + n);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", int'({dl_rst_a, dl_rst_b, ce_a, ce_b, inc, stp_clk, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", int'({dl_rst_a, dl_rst_b, ce_a, ce_b, inc, stp_clk, busy, done}), 0);
    chk("R1 start ignored while held low", pulses, 0);

    run(16, 32, 0);  // R6: no steps on either line
    run(16, 40, 0);  // R6: A untouched
    run(10, 32, 0);  // R6: B untouched
    run(0, 63, 0);   // R8: both clamped
    for (int a = 0; a < 64; a++) run(a, (a * 7) % 64, 0);
    for (int b = 0; b < 64; b++) run(30, b, 0);
    run(20, 25, 9);  // R9: mid-sequence start
    run(5, 50, -1);  // R9: start on the finishing edge

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule